// File: doc/BRIEF.md
# Multiplexed external bus controller

This block drives the external memory bus of an 8-bit processor core that uses 16-bit addresses. It runs on an internal clock four times faster than the bus. From that clock it makes the bus clock E. Each bus cycle lasts four internal clocks. E is low for the first two and high for the last two.

The upper address byte is driven on its own 8-bit output for the whole cycle. The lower address byte and the data share one 8-bit port. The low address is driven while E is low, and an address strobe lets outside logic latch it. Data moves while E is high, in the direction given by the read/write line.

The core offers a request made of valid, write enable, address and write data. The block accepts it during the last internal clock of the running cycle and shows the acceptance on `req_take`. When no request is offered, the block runs an idle read cycle on the last address. Read data is captured on the falling edge of E and returned with a one-clock valid pulse.

Top module: `mxb_bus_ctrl`

## Requirements
- R1: `e_clk` is periodic with four clocks per bus cycle: low for two consecutive clocks, then high for two.
- R2: `as_stb` is high for exactly one clock per cycle, the first clock of the E-low half. It is never high while `e_clk` is high, so it falls one clock before E rises.
- R3: `addr_hi` carries bits 15..8 of the cycle's address and changes only as a new cycle begins (the clock in which `as_stb` rises).
- R4: In both E-low clocks of every cycle after reset, `ad_oe` is 1 and `ad_out` carries address bits 7..0, unchanged across the fall of `as_stb`.
- R5: In a write cycle, `rw` is 0 and, for both E-high clocks, `ad_oe` is 1 with `ad_out` equal to the request's write data.
- R6: In a read cycle, `rw` is 1 and `ad_oe` is 0 while E is high. `ad_in` is sampled at the clock edge where E falls. `rd_valid` is then 1 for exactly that one following clock, with `rd_data` holding the sample.
- R7: `rw` changes only at a cycle boundary, so it stays low without a high pulse across consecutive write cycles.
- R8: `req_take` is 1 exactly in the last clock of a cycle (the second E-high clock), and the request present at that clock's rising edge is the next cycle's request. Without `req_valid` the next cycle is an idle read: it reuses the previous address, and `rd_valid` stays 0 after it.
- R9: During reset `e_clk`=0, `as_stb`=0, `rw`=1, `ad_oe`=0 and `rd_valid`=0. E rises at the first clock edge after reset is released. The first full cycle starts two clocks later, carrying the request taken at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, four times the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers a bus request |
| req_we | input | 1 | Request is a write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_take | output | 1 | Request is accepted at the next clock edge |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-clock pulse when `rd_data` is new |
| e_clk | output | 1 | Bus clock E |
| as_stb | output | 1 | Address strobe for the low address byte |
| rw | output | 1 | 1 = read, 0 = write |
| addr_hi | output | 8 | Address bits 15..8 |
| ad_out | output | 8 | Multiplexed port, output value |
| ad_oe | output | 1 | Multiplexed port output enable |
| ad_in | input | 8 | Multiplexed port, input value |

## Verification
A wrong phase count shows within one bus cycle. E loses its two-low, two-high shape, or the strobe lines up with E high. A stale or misrouted cycle register shows in the very next cycle. The high byte or the latched low byte then differs from the request, write data appears during a read, or `rw` pulses high between two writes. A wrong capture edge or a missing read qualifier shows one clock after E falls, as a wrong value or wrong timing on `rd_valid` and `rd_data`. The bench models an external memory that answers from the address it latched on the strobe. A broken address phase therefore also corrupts the returned data.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned HI_W   = ADDR_W - DATA_W;
    localparam int unsigned PH_W   = 2;

    typedef struct packed {
        logic              valid;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cyc_t;

    typedef struct packed {
        logic              e;
        logic              as;
        logic              rw;
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] ad_out;
        logic              ad_oe;
    } pin_t;
endpackage

// File: rtl/mxb_phase.sv
module mxb_phase
    import mxb_pkg::*;
#(
    parameter logic [PH_W-1:0] RESET_PH = 2'd1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph_d,
    output logic            last
);
    logic [PH_W-1:0] ph_q;

    always_comb begin
        ph_d = ph_q + 1'b1;
        last = (ph_q == {PH_W{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= RESET_PH;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/mxb_cycle_reg.sv
module mxb_cycle_reg
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output cyc_t              nxt,
    output logic              cur_rd
);
    cyc_t cyc_d, cyc_q;

    always_comb begin
        cyc_d = cyc_q;
        if (take) begin
            cyc_d.valid = req_valid;
            cyc_d.we    = req_valid && req_we;
            if (req_valid) begin
                cyc_d.addr  = req_addr;
                cyc_d.wdata = req_wdata;
            end
        end
        nxt    = cyc_d;
        cur_rd = cyc_q.valid && !cyc_q.we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_d;
    end
endmodule

// File: rtl/mxb_rd_capture.sv
module mxb_rd_capture
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              cur_rd,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t st_d, st_q;

    always_comb begin
        st_d.valid = take && cur_rd;
        st_d.data  = st_d.valid ? ad_in : st_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;
endmodule

// File: rtl/mxb_bus_ctrl.sv
module mxb_bus_ctrl
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_take,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              e_clk,
    output logic              as_stb,
    output logic              rw,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in
);
    logic [PH_W-1:0] ph_d;
    logic            last;
    cyc_t            nxt;
    logic            cur_rd;
    pin_t            pin_d, pin_q;

    mxb_phase #(.RESET_PH(2'd1)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph_d  (ph_d),
        .last  (last)
    );

    mxb_cycle_reg u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (last),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .nxt       (nxt),
        .cur_rd    (cur_rd)
    );

    mxb_rd_capture u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (last),
        .cur_rd   (cur_rd),
        .ad_in    (ad_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Pin values for the coming phase; phases 2 and 3 are the E-high half.
    always_comb begin
        pin_d.e      = ph_d[1];
        pin_d.as     = (ph_d == '0);
        pin_d.rw     = !nxt.we;
        pin_d.hi     = nxt.addr[ADDR_W-1:DATA_W];
        pin_d.ad_out = ph_d[1] ? nxt.wdata : nxt.addr[DATA_W-1:0];
        pin_d.ad_oe  = !ph_d[1] || nxt.we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q    <= '0;
            pin_q.rw <= 1'b1;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign req_take = last;
    assign e_clk    = pin_q.e;
    assign as_stb   = pin_q.as;
    assign rw       = pin_q.rw;
    assign addr_hi  = pin_q.hi;
    assign ad_out   = pin_q.ad_out;
    assign ad_oe    = pin_q.ad_oe;
endmodule

// File: rtl/mxb_bus_checker.sv
module mxb_bus_checker
    import mxb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              e_clk,
    input logic              as_stb,
    input logic              rw,
    input logic [HI_W-1:0]   addr_hi,
    input logic [DATA_W-1:0] ad_out,
    input logic              ad_oe,
    input logic              rd_valid
);
    // R1: E holds each level for two clocks
    p_e_high_two_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_clk) |=> e_clk);
    p_e_low_two_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_clk) |=> !e_clk);

    // R2: strobe lasts one clock and never overlaps E high
    p_as_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        as_stb |=> (!as_stb && !e_clk));
    p_as_e_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(as_stb && e_clk));

    // R3: high address moves only at a cycle start
    p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(as_stb) |-> $stable(addr_hi));

    // R4: low address driven and held across the strobe fall
    p_addr_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        as_stb |-> ad_oe);
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        as_stb |=> (ad_oe && $stable(ad_out)));

    // R5: write data driven while E is high
    p_write_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (e_clk && !rw) |-> ad_oe);

    // R6: port released during the data half of a read; data pulse at E fall
    p_read_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (e_clk && rw) |-> !ad_oe);
    p_rdv_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $fell(e_clk));

    // R7: direction changes only at a cycle start
    p_rw_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(as_stb) |-> $stable(rw));
endmodule

bind mxb_bus_ctrl mxb_bus_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .e_clk    (e_clk),
    .as_stb   (as_stb),
    .rw       (rw),
    .addr_hi  (addr_hi),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .rd_valid (rd_valid)
);

// File: tb/tb_mxb_bus_ctrl.sv
module tb_mxb_bus_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ       = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_take, rd_valid, e_clk, as_stb, rw, ad_oe;
    logic [7:0]  rd_data, addr_hi, ad_out, ad_in;
    logic [7:0]  lat_lo = '0;
    logic        prev_as = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // External memory answers from the latched address
    assign ad_in = mem({addr_hi, lat_lo});

    mxb_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_take(req_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .e_clk(e_clk), .as_stb(as_stb),
        .rw(rw), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
    );

    // Bench model of the bus state
    logic [1:0]  tb_ph = 2'd1;
    logic        cv = 0, cw = 0, rdv_exp = 0;
    logic [15:0] ca = '0;
    logic [7:0]  cd = '0, rdx = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            tb_ph = 2'd1; cv = 0; cw = 0; ca = '0; cd = '0; rdv_exp = 0;
        end else begin
            rdv_exp = (tb_ph == 2'd3) && cv && !cw;
            if (rdv_exp) rdx = mem(ca);
            if (tb_ph == 2'd3) begin
                cv = req_valid;
                cw = req_valid && req_we;
                if (req_valid) begin ca = req_addr; cd = req_wdata; end
            end
            tb_ph = tb_ph + 2'd1;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic drive_req(input int k);
        req_valid = (k % 5) != 4;
        req_we    = (k % 4) < 2;
        req_addr  = 16'(16'h1234 + k * 16'h0351);
        req_wdata = 8'(k * 37 + 5);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        int k = 0;
        drive_req(0);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(e_clk == 0, "R9 e", e_clk, 0);
        chk(as_stb == 0, "R9 as", as_stb, 0);
        chk(rw == 1, "R9 rw", rw, 1);
        chk(ad_oe == 0, "R9 oe", ad_oe, 0);
        chk(rd_valid == 0, "R9 rdv", rd_valid, 0);
        rst_n = 1'b1;
        // R9: E rises at the first edge after release
        @(negedge clk);
        chk(e_clk == 1, "R9 first E", e_clk, 1);
        for (int n = 0; n < NREQ * 4 + 8; n++) begin
            // R1: E level by phase
            chk(e_clk == (tb_ph >= 2), "R1 e", e_clk, tb_ph >= 2);
            // R2: strobe in first quarter only
            chk(as_stb == (tb_ph == 0), "R2 as", as_stb, tb_ph == 0);
            // R8: take in last quarter
            chk(req_take == (tb_ph == 3), "R8 take", req_take, tb_ph == 3);
            // R3: high address of the cycle
            chk(addr_hi == ca[15:8], "R3 hi", addr_hi, ca[15:8]);
            // R5/R6/R7: direction follows cycle type, no glitch
            chk(rw == !(cv && cw), "R7 rw", rw, !(cv && cw));
            if (tb_ph < 2) begin
                // R4: low address driven in the E-low half
                chk(ad_oe == 1, "R4 oe", ad_oe, 1);
                chk(ad_out == ca[7:0], "R4 lo", ad_out, ca[7:0]);
            end else if (cv && cw) begin
                chk(ad_oe == 1, "R5 oe", ad_oe, 1);
                chk(ad_out == cd, "R5 data", ad_out, cd);
            end else begin
                chk(ad_oe == 0, "R6 hiz", ad_oe, 0);
            end
            // R6/R8: read return, none after idle or write cycles
            chk(rd_valid == rdv_exp, "R6 rdv", rd_valid, rdv_exp);
            if (rdv_exp) chk(rd_data == rdx, "R6 rdata", rd_data, rdx);
            // R2: external latch on strobe fall, E still low
            if (prev_as && !as_stb) begin
                lat_lo = ad_out;
                chk(e_clk == 0, "R2 fall before E", e_clk, 0);
            end
            prev_as = as_stb;
            if (tb_ph == 0) begin
                k++;
                drive_req(k);
            end
            @(negedge clk);
        end
        finish_run();
    end
endmodule